// File: doc/BRIEF.md
# Block-Transfer I2C Configuration Target

This block is an I2C target that lets a host read and write a small bank of eight-bit configuration registers. It answers one fixed seven-bit address, 0x69, so the address byte is 0xD2 for a write and 0xD3 for a read. There is no register pointer. Every transfer starts at register 0 and moves upward one register per byte.

In a write, the two bytes that follow the address are a command byte and a count byte. The target acknowledges both and then discards them. The data bytes after them fill registers 0, 1, 2 and so on. In a read, the target first sends a fixed byte-count value and then the registers in ascending order. The transfer ends when the host does not acknowledge a byte.

The design samples SCL and SDA with a two-stage synchroniser on the system clock. It detects START and STOP from SDA edges that occur while SCL is high. It drives SDA through an active-high pull-down enable, which models an open-drain output. One bit of register 1 is read-only: it shows the inverted level of a strap input. The register contents come out on a flat bus for the rest of the chip. The target is meant for standard-mode timing at 100 kbit/s, with the system clock far faster than SCL.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). For any other address it leaves SDA released during the acknowledge bit, and the transfer changes no register.
- R2: In a write, every byte after a matching address is shifted in MSB first, and the target acknowledges it by pulling SDA low during the ninth clock.
- R3: Every transfer starts at register 0, and each following data byte goes to the next register index. A short write changes only the registers it reaches.
- R4: In a write, the first two bytes after the address (command and count) are acknowledged, but they change no register.
- R5: A read returns the byte count 0x09 first, then registers 0 to NUM_REGS-1 in ascending order, each MSB first.
- R6: When the host does not acknowledge a read byte, the target releases SDA at once. It keeps SDA released until the next START.
- R7: A write byte aimed beyond the last register is acknowledged and discarded. A read beyond the last register returns 0xFF.
- R8: Bit 7 of register 1 always reads as the inverse of `strap_i`, and writes to that bit have no effect.
- R9: A START in the middle of a transfer restarts the address phase. A STOP releases SDA and returns the target to idle.
- R10: After reset, the registers read 0x02, {~strap_i, 0x7F[6:0]}, 0xFF and 0xFF (registers 0 to 3 on cfg_o bits [7:0] up to [31:24]), and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 1 | Strap level reflected, inverted, in register 1 bit 7 |
| cfg_o | output | NUM_REGS*8 | Register contents, register k on bits [8k+7:8k] |

## Verification
The checker watches every cycle for the following:
- The SDA pull-down is enabled only right after a detected SCL falling edge.
- A STOP always leaves SDA released.
- A host NACK on a read byte drops the target to idle.
- The register outputs move only after a write strobe or a strap change.
- Write strobes happen only during a write-acknowledge phase.

Some behaviours show up only in the bench's transfers:
- Whether the correct bytes are skipped or stored.
- The order of the read-back data.
- The 0x09 count byte.
- The 0xFF padding.
- The effect of a repeated START.

The bench also sweeps several data patterns through full write and read bursts.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 4;
    localparam logic [BIT_CNT_W-1:0] BITS_DONE = 4'd8;
    localparam logic [BIT_CNT_W-1:0] LAST_TX_BIT = 4'd7;
    localparam int DUMMY_BYTES = 2;
    localparam logic [BYTE_W-1:0] PAD_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBIT,
        ST_WACK,
        ST_RBIT,
        ST_RACK
    } state_e;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // Byte sent for read position idx: count first, then registers, then padding.
    function automatic logic [BYTE_W-1:0] tx_pick(
        input logic [BYTE_W-1:0] idx,
        input logic [BYTE_W-1:0] count_val,
        input logic [BYTE_W-1:0] reg_val,
        input int                num_regs
    );
        if (idx == '0)
            return count_val;
        else if (int'(idx) <= num_regs)
            return reg_val;
        else
            return PAD_BYTE;
    endfunction

    function automatic logic [BYTE_W-1:0] sat_inc(input logic [BYTE_W-1:0] v);
        return (v == '1) ? v : v + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_d;
    logic       sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    assign sda_s     = sda_ff[1];
    assign scl_rise  = scl_ff[1] & ~scl_d;
    assign scl_fall  = ~scl_ff[1] & scl_d;
    assign start_det = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
    assign stop_det  = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];

endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank #(
    parameter int                    NUM_REGS  = 4,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = 32'hFFFF_7F02,
    parameter int                    STRAP_REG = 1,
    parameter int                    STRAP_BIT = 7,
    localparam int                   AW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  strap_i,
    input  i2c_cfg_pkg::wr_req_t  wr_req,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    logic [7:0] store [NUM_REGS];
    logic [7:0] view  [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RO_MASK =
            (g == STRAP_REG) ? (8'h01 << STRAP_BIT) : 8'h00;

        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= RESET_VAL[g*8 +: 8];
            else if (wr_req.en && (int'(wr_req.idx) == g))
                store[g] <= wr_req.data;
        end

        assign view[g] = (store[g] & ~RO_MASK) | ({8{~strap_i}} & RO_MASK);
        assign cfg_o[g*8 +: 8] = view[g];
    end

    assign rd_data = view[rd_addr];

endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS  = 4,
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter logic [7:0] COUNT_VAL = 8'h09,
    localparam int        AW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_s,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output wr_req_t       wr_req,
    output logic          sda_oe_o,
    output state_e        state_o
);
    localparam logic [7:0] LAST_WR_IDX = 8'(DUMMY_BYTES + NUM_REGS - 1);
    localparam logic [7:0] FIRST_WR_IDX = 8'(DUMMY_BYTES);

    state_e                state;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [7:0]            rx_sh;
    logic [7:0]            tx_sh;
    logic [7:0]            xfer_idx;
    logic [7:0]            tx_next;
    logic [7:0]            reg_slot;

    assign reg_slot = xfer_idx - 8'd1;
    assign rd_addr  = reg_slot[AW-1:0];
    assign tx_next  = tx_pick(xfer_idx, COUNT_VAL, rd_data, NUM_REGS);
    assign state_o  = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            xfer_idx <= '0;
            sda_oe_o <= 1'b0;
            wr_req   <= '0;
        end else begin
            wr_req.en <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR, ST_WBIT: begin
                        if (scl_rise && bit_cnt != BITS_DONE) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS_DONE) begin
                            if (state == ST_ADDR) begin
                                xfer_idx <= '0;
                                if (rx_sh[7:1] == DEV_ADDR) begin
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_AACK;
                                    tx_sh    <= {7'd0, rx_sh[0]};
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe_o <= 1'b1;
                                state    <= ST_WACK;
                                xfer_idx <= sat_inc(xfer_idx);
                                if (xfer_idx >= FIRST_WR_IDX && xfer_idx <= LAST_WR_IDX) begin
                                    wr_req.en   <= 1'b1;
                                    wr_req.idx  <= xfer_idx - FIRST_WR_IDX;
                                    wr_req.data <= rx_sh;
                                end
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (tx_sh[0]) begin
                                tx_sh    <= tx_next;
                                sda_oe_o <= ~tx_next[7];
                                xfer_idx <= sat_inc(xfer_idx);
                                state    <= ST_RBIT;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_WBIT;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_WBIT;
                        end
                    end
                    ST_RBIT: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_TX_BIT) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                tx_sh    <= {tx_sh[6:0], 1'b0};
                                sda_oe_o <= ~tx_sh[6];
                                bit_cnt  <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && sda_s) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            tx_sh    <= tx_next;
                            sda_oe_o <= ~tx_next[7];
                            xfer_idx <= sat_inc(xfer_idx);
                            bit_cnt  <= '0;
                            state    <= ST_RBIT;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter int                    NUM_REGS  = 4,
    parameter logic [6:0]            DEV_ADDR  = 7'h69,
    parameter logic [7:0]            COUNT_VAL = 8'h09,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = 32'hFFFF_7F02,
    parameter int                    STRAP_REG = 1,
    parameter int                    STRAP_BIT = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  strap_i,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic          scl_rise;
    logic          scl_fall;
    logic          sda_s;
    logic          start_det;
    logic          stop_det;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;
    wr_req_t       wr_req;
    state_e        state;

    i2c_cfg_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_cfg_engine #(
        .NUM_REGS  (NUM_REGS),
        .DEV_ADDR  (DEV_ADDR),
        .COUNT_VAL (COUNT_VAL)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_req    (wr_req),
        .sda_oe_o  (sda_oe_o),
        .state_o   (state)
    );

    i2c_cfg_bank #(
        .NUM_REGS  (NUM_REGS),
        .RESET_VAL (RESET_VAL),
        .STRAP_REG (STRAP_REG),
        .STRAP_BIT (STRAP_BIT)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .strap_i (strap_i),
        .wr_req  (wr_req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sda_oe_o,
    input logic                  strap_i,
    input logic [NUM_REGS*8-1:0] cfg_o,
    input logic                  scl_rise,
    input logic                  scl_fall,
    input logic                  sda_s,
    input logic                  stop_det,
    input state_e                state,
    input wr_req_t               wr_req
);
    // R2 / R5: SDA is pulled low only right after a detected SCL falling edge
    p_drive_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> $past(scl_fall));

    // R9: a STOP always leaves SDA released and the target idle
    p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!sda_oe_o && state == ST_IDLE));

    // R6: host NACK on a read byte ends the transfer with SDA released
    p_nack_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK && scl_rise && sda_s) |=> (state == ST_IDLE && !sda_oe_o));

    // R6 / R1: idle target never drives the bus
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe_o);

    // R4 / R3: register writes only at a write-acknowledge step
    p_wr_in_ack_r4: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> state == ST_WACK);

    // R8 / R1: register outputs move only after a write strobe or a strap change
    p_regs_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_req.en) && $stable(strap_i)) |-> $stable(cfg_o));

endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe_o (sda_oe_o),
    .strap_i  (strap_i),
    .cfg_o    (cfg_o),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .stop_det (stop_det),
    .state    (state),
    .wr_req   (wr_req)
);

// File: tb/i2c_cfg_target_tb.sv
module i2c_cfg_target_tb;
    localparam int N = 4;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_drive = 1'b0;
    logic strap = 1'b0;
    logic sda_oe;
    logic [N*8-1:0] cfg;
    wire  sda_line = ~(m_drive | sda_oe);

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] exp_reg [N];
    logic [7:0] wbuf [12];

    always #2.5 clk = ~clk;

    i2c_cfg_target u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .cfg_o    (cfg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    function automatic logic [7:0] view(input int i);
        return (i == 1) ? {~strap, exp_reg[1][6:0]} : exp_reg[i];
    endfunction

    task automatic chk_regs(input string req);
        for (int i = 0; i < N; i++) chk(req, cfg[i*8 +: 8], view(i));
    endtask

    task automatic m_start();
        m_drive = 1'b0; qw();
        m_scl = 1'b1;   qw();
        m_drive = 1'b1; qw();
        m_scl = 1'b0;   qw();
    endtask

    task automatic m_stop();
        m_drive = 1'b1; qw();
        m_scl = 1'b1;   qw();
        m_drive = 1'b0; qw(); qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_drive = ~b[i]; qw();
            m_scl = 1'b1;    qw(); qw();
            m_scl = 1'b0;    qw();
        end
        m_drive = 1'b0; qw();
        m_scl = 1'b1;   qw();
        acked = ~sda_line; qw();
        m_scl = 1'b0;   qw();
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        m_drive = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qw();
            m_scl = 1'b1; qw();
            b[i] = sda_line; qw();
            m_scl = 1'b0; qw();
        end
        m_drive = ack; qw();
        m_scl = 1'b1;  qw(); qw();
        m_scl = 1'b0;  qw();
        m_drive = 1'b0;
    endtask

    // write: address 0xD2, command, count, then n data bytes from wbuf
    task automatic do_write(input int n, input string req);
        logic a;
        m_start();
        send_byte(8'hD2, a); chk({req, " addr ack"}, a, 1'b1);
        send_byte(8'h3C, a); chk("R4 command ack", a, 1'b1);
        send_byte(8'hC3, a); chk("R4 count ack", a, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk({req, " R2 data ack"}, a, 1'b1);
            if (i < N) exp_reg[i] = wbuf[i];
        end
        m_stop();
    endtask

    // read: count byte, all registers, one pad byte, NACK on last
    task automatic do_read(input string req);
        logic a;
        logic [7:0] b;
        m_start();
        send_byte(8'hD3, a); chk("R1 read addr ack", a, 1'b1);
        recv_byte(1'b1, b); chk("R5 count byte", b, 8'h09);
        for (int i = 0; i < N; i++) begin
            recv_byte(1'b1, b); chk({req, " R5 reg order"}, b, view(i));
        end
        recv_byte(1'b0, b); chk("R7 pad byte", b, 8'hFF);
        chk("R6 release after nack", sda_oe, 1'b0);
        m_scl = 1'b1; qw(); chk("R6 still released", sda_line, 1'b1);
        m_scl = 1'b0; qw();
        m_stop();
        chk("R9 released after stop", sda_oe, 1'b0);
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        exp_reg[0] = 8'h02; exp_reg[1] = 8'h7F; exp_reg[2] = 8'hFF; exp_reg[3] = 8'hFF;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        chk_regs("R10 reset regs");
        chk("R10 reset sda", sda_oe, 1'b0);

        // wrong addresses
        m_start();
        send_byte(8'hA0, a); chk("R1 foreign addr nack", a, 1'b0);
        send_byte(8'h11, a); chk("R1 no ack after foreign", a, 1'b0);
        m_stop();
        m_start();
        send_byte(8'hD1, a); chk("R1 near addr nack", a, 1'b0);
        m_stop();
        chk_regs("R1 regs untouched");

        // full write plus one extra byte
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h99;
        do_write(5, "R7");
        chk_regs("R4 R3 R8 after write");
        do_read("R3");

        // short write touches reg0 only
        wbuf[0] = 8'hA5;
        do_write(1, "R3");
        chk_regs("R3 short write");

        // repeated start mid-write restarts address phase
        m_start();
        send_byte(8'hD2, a); chk("R9 addr ack", a, 1'b1);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h5A, a); exp_reg[0] = 8'h5A;
        m_start();
        send_byte(8'hD3, a); chk("R9 restart ack", a, 1'b1);
        recv_byte(1'b1, b); chk("R9 restart count", b, 8'h09);
        recv_byte(1'b0, b); chk("R9 restart reg0", b, 8'h5A);
        m_stop();

        // strap-driven read-only bit
        strap = 1'b1; qw();
        chk_regs("R8 strap high");
        wbuf[0] = 8'h5A; wbuf[1] = 8'hFF;
        do_write(2, "R8");
        chk("R8 ro bit ignores write", cfg[15], 1'b0);
        chk_regs("R8 after write");
        strap = 1'b0; qw();
        chk("R8 strap low", cfg[15], 1'b1);

        // pattern sweep
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < N; i++) wbuf[i] = 8'((p * 53 + i * 29 + 7) ^ (p << 4));
            strap = p[0];
            do_write(N, "R3");
            chk_regs("R3 sweep regs");
            do_read("R5");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule